// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM from reset to a usable state. While reset is held it keeps the clock-enable low and drives NOP. After reset is released it raises clock-enable. It then steps through the mandatory power-up command order, which covers three things: enabling the on-die delay-locked loop, programming the mode register with a DLL reset, and issuing two refreshes. Between any two commands it inserts programmable runs of NOP. At the end it asserts a ready flag. The run-time command path may issue normal traffic, READs included, once that flag is high.

The mode word carries the burst length, the burst type and the CAS latency, all taken from configuration pins. The wait lengths are configuration pins too, in clocks: the settle time after clock-enable rises, the precharge time, the mode-register time and the refresh time. Another pin selects whether a final mode-register write clears the DLL reset bit.

A separate counter starts on the mode-register write that resets the DLL. The ready flag cannot rise until that counter has seen the lock window of clocks (200 by default). This holds even if the rest of the sequence finished earlier.

Top module: `ddr_init_seq`

## Requirements
- R1: While rst_n is low, cke is 0, init_done is 0 and the command pins {cs_n,ras_n,cas_n,we_n} read NOP = 4'b0111. In the first cycle after release cke becomes 1, and it stays 1 until the next reset.
- R2: The first non-NOP command is PRECHARGE ALL ({cs_n,ras_n,cas_n,we_n}=4'b0010, addr bit 10 = 1, other addr bits 0, ba 0). It appears cfg_cke_wait+1 cycles after the first cycle with cke high.
- R3: The commands are issued in this fixed order: PRECHARGE ALL; LOAD MODE (4'b0000) with ba=1 and addr=0 (bit 0 = 0, DLL enabled); LOAD MODE with ba=0 and addr bit 8 = 1 (DLL reset); PRECHARGE ALL; AUTO REFRESH (4'b0001, ba 0, addr 0); a second AUTO REFRESH; and, only when cfg_dll_clear=1, a LOAD MODE with ba=0 and addr bit 8 = 0.
- R4: The base mode word places the burst length code in addr[2:0], the burst type in addr[3] and the CAS latency code in addr[6:4]. All other bits are 0 apart from bit 8.
  - cfg_burst_len 0/1/2/3 gives 3'b001/3'b010/3'b011/3'b011, which is burst 2/4/8, with 3 also meaning 8.
  - addr[3] equals cfg_interleave.
  - cfg_cas_lat 0/1/2/3 gives 3'b010/3'b110/3'b011/3'b011, which is latency 2/2.5/3, with 3 also meaning 3.
- R5: After a PRECHARGE there are exactly cfg_trp NOP cycles before the next command. After a LOAD MODE there are exactly cfg_tmrd, and after an AUTO REFRESH exactly cfg_trfc. A value of 0 puts the next command in the very next cycle.
- R6: The sequence finishes in cycle F, the cycle after the last gap. Let M be the cycle of the DLL-reset LOAD MODE and L be DLL_LOCK_CYC. init_done rises in cycle max(F, M+L+1)+1, so it is never earlier than L cycles after the DLL reset.
- R7: Once high, init_done stays high and the command pins stay NOP until reset.
- R8: Asserting reset in the middle of the sequence, including during the DLL lock count, returns the block to the R1 state. After the next release, the full sequence and the full lock count run again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | 2 | Burst length select: 0=2, 1=4, 2 or 3=8 |
| cfg_interleave | input | 1 | Burst type: 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 2 | CAS latency select: 0=2, 1=2.5, 2 or 3=3 |
| cfg_dll_clear | input | 1 | Issue a final mode write with DLL reset cleared |
| cfg_cke_wait | input | CNT_W | NOP cycles after cke rises |
| cfg_trp | input | CNT_W | NOP cycles after a precharge |
| cfg_tmrd | input | CNT_W | NOP cycles after a mode write |
| cfg_trfc | input | CNT_W | NOP cycles after a refresh |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address / mode word |
| init_done | output | 1 | Memory ready for normal commands |

## Verification
The hardest situation to reach is the handover between the end of the command sequence and the end of the DLL lock window. This matters most when the two are one cycle apart, or when the sequence outlasts the window.

The stimulus table sets the refresh gap so that the sequence ends exactly one cycle before lock. A second entry sets the gap long enough that lock has already expired when the sequence ends. In both cases the ready cycle is predicted from the recorded DLL-reset cycle.

A reset is also applied while the lock counter is part-way through its count. The next full run is then checked for a ready cycle that shows no carried-over progress.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_HOLD,
    ST_CKE_ON,
    ST_PRE_A,
    ST_EXT_LMR,
    ST_BASE_RST,
    ST_PRE_B,
    ST_REF_A,
    ST_REF_B,
    ST_BASE_CLR,
    ST_LOCK_WAIT,
    ST_READY
  } init_step_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam cmd_pins_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam cmd_pins_t CMD_LMR = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  localparam int AP_BIT      = 10;
  localparam int DLL_RST_BIT = 8;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CNT_W'(1));

  // R5: the final wait cycle is followed by an idle timer unless reloaded
  assert_last_then_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !load_i) |=> !busy_o);

endmodule

// File: rtl/ddr_dll_lock_ctr.sv
module ddr_dll_lock_ctr #(
  parameter int LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic locked_o
);

  localparam int LCW = $clog2(LOCK_CYC + 1);

  logic [LCW-1:0] cnt_q;
  logic           armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= LCW'(LOCK_CYC);
      armed_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - LCW'(1);
    end
  end

  assign locked_o = armed_q && (cnt_q == '0);

  // R6: lock, once reached, is kept until a new DLL reset
  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !start_i) |=> locked_o);

endmodule

// File: rtl/ddr_mode_word.sv
module ddr_mode_word #(
  parameter int ADDR_W = 12
) (
  input  logic [1:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic [1:0]        cfg_cas_lat,
  input  logic              dll_rst_i,
  output logic [ADDR_W-1:0] word_o
);

  import ddr_init_pkg::*;

  logic [2:0] bl_code;
  logic [2:0] cl_code;

  always_comb begin
    unique case (cfg_burst_len)
      2'd0:    bl_code = 3'b001;
      2'd1:    bl_code = 3'b010;
      default: bl_code = 3'b011;
    endcase
    unique case (cfg_cas_lat)
      2'd0:    cl_code = 3'b010;
      2'd1:    cl_code = 3'b110;
      default: cl_code = 3'b011;
    endcase
    word_o              = '0;
    word_o[2:0]         = bl_code;
    word_o[3]           = cfg_interleave;
    word_o[6:4]         = cl_code;
    word_o[DLL_RST_BIT] = dll_rst_i;
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int ADDR_W       = 12,
  parameter int BA_W         = 2,
  parameter int CNT_W        = 8,
  parameter int DLL_LOCK_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic [1:0]        cfg_cas_lat,
  input  logic              cfg_dll_clear,
  input  logic [CNT_W-1:0]  cfg_cke_wait,
  input  logic [CNT_W-1:0]  cfg_trp,
  input  logic [CNT_W-1:0]  cfg_tmrd,
  input  logic [CNT_W-1:0]  cfg_trfc,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  import ddr_init_pkg::*;

  init_step_e       step_q, step_d, step_succ;
  logic             gap_busy, gap_last, gap_load;
  logic [CNT_W-1:0] gap_sel;
  logic             issue;
  logic             dll_locked;
  logic [ADDR_W-1:0] mode_rst, mode_clr;
  cmd_pins_t        cmd;

  ddr_init_timer #(.CNT_W(CNT_W)) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (gap_load),
    .load_val_i (gap_sel),
    .busy_o     (gap_busy),
    .last_o     (gap_last)
  );

  ddr_dll_lock_ctr #(.LOCK_CYC(DLL_LOCK_CYC)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (issue && (step_q == ST_BASE_RST)),
    .locked_o (dll_locked)
  );

  ddr_mode_word #(.ADDR_W(ADDR_W)) u_mw_rst (
    .cfg_burst_len  (cfg_burst_len),
    .cfg_interleave (cfg_interleave),
    .cfg_cas_lat    (cfg_cas_lat),
    .dll_rst_i      (1'b1),
    .word_o         (mode_rst)
  );

  ddr_mode_word #(.ADDR_W(ADDR_W)) u_mw_clr (
    .cfg_burst_len  (cfg_burst_len),
    .cfg_interleave (cfg_interleave),
    .cfg_cas_lat    (cfg_cas_lat),
    .dll_rst_i      (1'b0),
    .word_o         (mode_clr)
  );

  // a command goes out only in a step's first cycle, never inside a gap
  always_comb begin
    issue = 1'b0;
    if (!gap_busy) begin
      unique case (step_q)
        ST_CKE_ON, ST_PRE_A, ST_EXT_LMR, ST_BASE_RST,
        ST_PRE_B, ST_REF_A, ST_REF_B, ST_BASE_CLR: issue = 1'b1;
        default:                                   issue = 1'b0;
      endcase
    end
  end

  always_comb begin
    unique case (step_q)
      ST_CKE_ON:                            gap_sel = cfg_cke_wait;
      ST_PRE_A, ST_PRE_B:                   gap_sel = cfg_trp;
      ST_EXT_LMR, ST_BASE_RST, ST_BASE_CLR: gap_sel = cfg_tmrd;
      ST_REF_A, ST_REF_B:                   gap_sel = cfg_trfc;
      default:                              gap_sel = '0;
    endcase
  end

  always_comb begin
    unique case (step_q)
      ST_HOLD:     step_succ = ST_CKE_ON;
      ST_CKE_ON:   step_succ = ST_PRE_A;
      ST_PRE_A:    step_succ = ST_EXT_LMR;
      ST_EXT_LMR:  step_succ = ST_BASE_RST;
      ST_BASE_RST: step_succ = ST_PRE_B;
      ST_PRE_B:    step_succ = ST_REF_A;
      ST_REF_A:    step_succ = ST_REF_B;
      ST_REF_B:    step_succ = cfg_dll_clear ? ST_BASE_CLR : ST_LOCK_WAIT;
      ST_BASE_CLR: step_succ = ST_LOCK_WAIT;
      default:     step_succ = ST_READY;
    endcase
  end

  assign gap_load = issue && (gap_sel != '0);

  always_comb begin
    step_d = step_q;
    if (step_q == ST_HOLD) begin
      step_d = ST_CKE_ON;
    end else if (issue) begin
      if (gap_sel == '0) step_d = step_succ;
    end else if (gap_busy) begin
      if (gap_last) step_d = step_succ;
    end else if (step_q == ST_LOCK_WAIT) begin
      if (dll_locked) step_d = ST_READY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_HOLD;
    else        step_q <= step_d;
  end

  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    if (issue) begin
      unique case (step_q)
        ST_PRE_A, ST_PRE_B: begin
          cmd          = CMD_PRE;
          addr[AP_BIT] = 1'b1;
        end
        ST_EXT_LMR: begin
          cmd = CMD_LMR;
          ba  = BA_W'(1);
        end
        ST_BASE_RST: begin
          cmd  = CMD_LMR;
          addr = mode_rst;
        end
        ST_BASE_CLR: begin
          cmd  = CMD_LMR;
          addr = mode_clr;
        end
        ST_REF_A, ST_REF_B: cmd = CMD_REF;
        default:            cmd = CMD_NOP;
      endcase
    end
  end

  assign cs_n      = cmd.cs_n;
  assign ras_n     = cmd.ras_n;
  assign cas_n     = cmd.cas_n;
  assign we_n      = cmd.we_n;
  assign cke       = (step_q != ST_HOLD);
  assign init_done = (step_q == ST_READY);

  // R1: clock enable never drops again once raised
  assert_cke_stays_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  // R5: a command with a non-zero gap is followed by NOP
  assert_gap_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (gap_sel != '0)) |=> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

  // R6: ready only with the DLL lock window complete
  assert_done_after_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> dll_locked);

  // R7: ready is sticky and quiet
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && ({cs_n, ras_n, cas_n, we_n} == 4'b0111)));

endmodule

// File: tb/tb_ddr_init_seq.sv
module tb_ddr_init_seq;

  localparam int ADDR_W = 12;
  localparam int BA_W   = 2;
  localparam int CNT_W  = 8;
  localparam int LOCK   = 200;
  localparam int NVEC   = 5;

  typedef struct packed {
    logic [1:0] bl;
    logic       bt;
    logic [1:0] cl;
    logic       clr;
    logic [7:0] ckew;
    logic [7:0] trp;
    logic [7:0] tmrd;
    logic [7:0] trfc;
  } vec_t;

  // rows: burst, type, latency, clear, cke wait, trp, tmrd, trfc
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 1'b0, 2'd0, 1'b1, 8'd3, 8'd2, 8'd2, 8'd10},
    '{2'd2, 1'b1, 2'd1, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0},
    '{2'd0, 1'b0, 2'd2, 1'b1, 8'd5, 8'd3, 8'd2, 8'd120},
    '{2'd1, 1'b1, 2'd2, 1'b0, 8'd2, 8'd1, 8'd1, 8'd97},
    '{2'd3, 1'b0, 2'd3, 1'b1, 8'd1, 8'd1, 8'd0, 8'd5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_burst_len = '0;
  logic cfg_interleave = 1'b0;
  logic [1:0] cfg_cas_lat = '0;
  logic cfg_dll_clear = 1'b0;
  logic [CNT_W-1:0] cfg_cke_wait = '0, cfg_trp = '0, cfg_tmrd = '0, cfg_trfc = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [BA_W-1:0] ba;
  logic [ADDR_W-1:0] addr;

  always #2 clk = ~clk;

  ddr_init_seq #(.ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W), .DLL_LOCK_CYC(LOCK)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_burst_len(cfg_burst_len), .cfg_interleave(cfg_interleave),
    .cfg_cas_lat(cfg_cas_lat), .cfg_dll_clear(cfg_dll_clear), .cfg_cke_wait(cfg_cke_wait),
    .cfg_trp(cfg_trp), .cfg_tmrd(cfg_tmrd), .cfg_trfc(cfg_trfc), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
  );

  int total = 0;
  int bad = 0;
  int wd_cyc = 0;

  int exp_n;
  int exp_cyc [10];
  logic [3:0] exp_cmd [10];
  int exp_ba [10];
  int exp_addr [10];
  int exp_done;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mode_word(input vec_t v, input bit rst);
    logic [2:0] b, c;
    b = (v.bl == 2'd0) ? 3'b001 : (v.bl == 2'd1) ? 3'b010 : 3'b011;
    c = (v.cl == 2'd0) ? 3'b010 : (v.cl == 2'd1) ? 3'b110 : 3'b011;
    return int'({3'b000, rst, 1'b0, c, v.bt, b});
  endfunction

  task automatic push(input int cyc, input logic [3:0] cmd, input int b, input int a);
    exp_cyc[exp_n]  = cyc;
    exp_cmd[exp_n]  = cmd;
    exp_ba[exp_n]   = b;
    exp_addr[exp_n] = a;
    exp_n++;
  endtask

  task automatic build_exp(input vec_t v);
    int c, m;
    exp_n = 0;
    c = 1 + int'(v.ckew);
    push(c, 4'b0010, 0, 1 << 10);
    c += 1 + int'(v.trp);
    push(c, 4'b0000, 1, 0);
    c += 1 + int'(v.tmrd);
    push(c, 4'b0000, 0, mode_word(v, 1'b1));
    m = c;
    c += 1 + int'(v.tmrd);
    push(c, 4'b0010, 0, 1 << 10);
    c += 1 + int'(v.trp);
    push(c, 4'b0001, 0, 0);
    c += 1 + int'(v.trfc);
    push(c, 4'b0001, 0, 0);
    c += 1 + int'(v.trfc);
    if (v.clr) begin
      push(c, 4'b0000, 0, mode_word(v, 1'b0));
      c += 1 + int'(v.tmrd);
    end
    exp_done = ((c > m + LOCK + 1) ? c : (m + LOCK + 1)) + 1;
  endtask

  task automatic apply_cfg(input vec_t v);
    cfg_burst_len  = v.bl;
    cfg_interleave = v.bt;
    cfg_cas_lat    = v.cl;
    cfg_dll_clear  = v.clr;
    cfg_cke_wait   = v.ckew;
    cfg_trp        = v.trp;
    cfg_tmrd       = v.tmrd;
    cfg_trfc       = v.trfc;
  endtask

  task automatic check_reset_state();
    chk(cke == 1'b0, "R1 cke in reset", int'(cke), 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 nop in reset", int'({cs_n, ras_n, cas_n, we_n}), 7);
    chk(init_done == 1'b0, "R1 done in reset", int'(init_done), 0);
  endtask

  task automatic run_vec(input vec_t v);
    int got_n, first_done, cke_low, late_cmd;
    int got_cyc [10];
    logic [3:0] got_cmd [10];
    int got_ba [10];
    int got_addr [10];
    apply_cfg(v);
    build_exp(v);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    got_n = 0; first_done = -1; cke_low = 0; late_cmd = 0;
    for (int cyc = 0; cyc <= exp_done + 4 && cyc < 900; cyc++) begin
      @(negedge clk);
      if (!cke) cke_low++;
      if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
        if (first_done >= 0) late_cmd++;
        if (got_n < 10) begin
          got_cyc[got_n]  = cyc;
          got_cmd[got_n]  = {cs_n, ras_n, cas_n, we_n};
          got_ba[got_n]   = int'(ba);
          got_addr[got_n] = int'(addr);
        end
        got_n++;
      end
      if (first_done >= 0 && !init_done) late_cmd++;
      if (init_done && first_done < 0) first_done = cyc;
    end
    chk(cke_low == 0, "R1 cke high after release", cke_low, 0);
    chk(got_n == exp_n, "R3 command count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_cyc[i] == exp_cyc[i], (i == 0) ? "R2 first command cycle" : "R5 command spacing",
          got_cyc[i], exp_cyc[i]);
      chk(got_cmd[i] == exp_cmd[i], "R3 command code", int'(got_cmd[i]), int'(exp_cmd[i]));
      chk(got_ba[i] == exp_ba[i], "R3 bank", got_ba[i], exp_ba[i]);
      chk(got_addr[i] == exp_addr[i], "R4 address word", got_addr[i], exp_addr[i]);
    end
    chk(first_done == exp_done, "R6 ready cycle", first_done, exp_done);
    chk(late_cmd == 0, "R7 quiet and sticky after ready", late_cmd, 0);
  endtask

  always @(posedge clk) begin
    wd_cyc++;
    if (wd_cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", wd_cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    apply_cfg(VECS[0]);
    repeat (3) @(negedge clk);
    check_reset_state();  // R1

    // table walk: R2..R7 across burst, latency, gap and lock-boundary settings
    for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

    // R8: reset while the lock count is running, then a full rerun
    apply_cfg(VECS[0]);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cke == 1'b0, "R8 cke after mid reset", int'(cke), 0);
    chk(init_done == 1'b0, "R8 done after mid reset", int'(init_done), 0);
    run_vec(VECS[0]);   // R8 restart checked against full timing

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule